// File: doc/BRIEF.md
# Spare Memory Migration Controller

This controller moves the contents of a failing memory region (a rank or a column of devices) onto a spare device while the system keeps running. A sparing request names the failing region. The controller fences host traffic to that region and waits for accesses already in flight to drain. It then copies the region word by word into the spare, carrying each full 72-bit codeword (data and check bits) unchanged. After the copy it redirects the region's address mapping to the spare, lifts the fence and flags that the failed device needs replacing.

The FSM has six states: `ST_IDLE`, `ST_HALT`, `ST_COPY`, `ST_SWITCH`, `ST_RESUME` and `ST_DONE`. The transitions are:
- IDLE→HALT on an accepted request.
- HALT→COPY once the host is no longer busy on the region.
- COPY→SWITCH when the last word's write is acknowledged.
- SWITCH→RESUME, RESUME→DONE and DONE→IDLE, each unconditionally.

Inside COPY, a copy engine cycles through the phases READ (issue the read), WAIT (await the data) and WRITE (hold the write until it is acknowledged). The spare-available flag is cleared when a request is accepted. Once the failed module has been exchanged, software pulses `spare_restock`. The new module then serves as the spare for the next hard error, and the existing mapping stays in place.

Top module: `spare_migrator`

## Requirements
- R1: A request on `spare_req` is accepted only in IDLE while `spare_avail` is 1. An accepted request raises `busy` on the next cycle. Any other request is ignored: there is no copy traffic, and the mapping is unchanged.
- R2: From acceptance through SWITCH, `host_stall` is 1 exactly when `host_region` equals the latched failing region. No copy read is issued while `host_busy` is 1 in HALT.
- R3: The copy reads the failing region (`rd_region`) at word addresses 0 to WORDS-1 in ascending order. For each word it issues one read, then one write to the spare at the same address. The write carries the 72-bit read codeword unmodified.
- R4: The mapping changes only in SWITCH, in a single cycle. Afterwards `host_to_spare` is 1 for the migrated region and 0 for every other region.
- R5: After SWITCH, `host_stall` drops, `replace_needed` goes to 1 and `busy` returns to 0.
- R6: `spare_avail` clears on acceptance and stays 0 during copy traffic. In IDLE, a `spare_restock` pulse sets `spare_avail`, clears `replace_needed` and leaves the mapping unchanged.
- R7: A `spare_restock` pulse outside IDLE is ignored.
- R8: After reset: `busy`=0, `spare_avail`=1, `replace_needed`=0, `host_to_spare`=0, and no copy request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spare_req | input | 1 | Request to spare a region (pulse) |
| spare_target | input | RID_W | Failing region index |
| spare_restock | input | 1 | Software pulse: a spare is installed again |
| host_busy | input | 1 | Host accesses to the failing region still outstanding |
| host_region | input | RID_W | Region of the current host access |
| host_stall | output | 1 | Host access to this region must wait |
| host_to_spare | output | 1 | Host access to this region goes to the spare |
| rd_req | output | 1 | Copy read request (one cycle) |
| rd_region | output | RID_W | Region read by the copy |
| rd_addr | output | IDX_W | Word address of the copy read |
| rd_valid | input | 1 | Read codeword valid |
| rd_data | input | CW_W | Read codeword, data plus check bits |
| wr_req | output | 1 | Copy write request to the spare, held until acknowledged |
| wr_addr | output | IDX_W | Word address of the copy write |
| wr_data | output | CW_W | Codeword written to the spare |
| wr_ack | input | 1 | Spare write accepted |
| busy | output | 1 | Migration in progress |
| spare_avail | output | 1 | A spare is available |
| replace_needed | output | 1 | The failed module should be replaced |

## Verification
Assertions check the following on every cycle:
- An idle controller without a spare stays idle.
- HALT holds while the host is still busy.
- Copy traffic occurs only behind the fence and with the spare flag cleared.
- Every write carries the codeword read just before it.
- The mapping moves only in SWITCH.
- The replacement flag rises only once the mapping is active.

Only the bench scenarios can show the following:
- The full ascending word sequence and its contents, through a scoreboard of expected codewords.
- Which regions end up stalled or redirected.
- That late requests and restock pulses leave no trace.
- That a second migration moves the mapping to a new region.

// File: rtl/spare_mig_pkg.sv
package spare_mig_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_HALT, ST_COPY, ST_SWITCH, ST_RESUME, ST_DONE
    } mig_state_t;

    typedef enum logic [1:0] {
        PH_READ, PH_WAIT, PH_WRITE
    } copy_phase_t;
endpackage

// File: rtl/mig_fsm.sv
module mig_fsm
    import spare_mig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       restock,
    input  logic       host_busy,
    input  logic       copy_done,
    output mig_state_t state,
    output logic       accept,
    output logic       spare_avail,
    output logic       replace_needed
);
    mig_state_t nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and acceptance
    always_comb begin
        accept = (state == ST_IDLE) && req && spare_avail;
        nxt    = state;
        unique case (state)
            ST_IDLE:   if (accept)     nxt = ST_HALT;
            ST_HALT:   if (!host_busy) nxt = ST_COPY;
            ST_COPY:   if (copy_done)  nxt = ST_SWITCH;
            ST_SWITCH: nxt = ST_RESUME;
            ST_RESUME: nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // spare availability and replacement flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spare_avail    <= 1'b1;
            replace_needed <= 1'b0;
        end else begin
            if (accept) begin
                spare_avail <= 1'b0;
            end else if (state == ST_IDLE && restock) begin
                spare_avail    <= 1'b1;
                replace_needed <= 1'b0;
            end
            if (state == ST_DONE) replace_needed <= 1'b1;
        end
    end

    assert_idle_no_spare_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !spare_avail) |=> state == ST_IDLE);

    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && host_busy) |=> state == ST_HALT);
endmodule

// File: rtl/copy_engine.sv
module copy_engine
    import spare_mig_pkg::*;
#(
    parameter  int CW_W  = 72,
    parameter  int WORDS = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic             rd_valid,
    input  logic [CW_W-1:0]  rd_data,
    input  logic             wr_ack,
    output logic             rd_req,
    output logic             wr_req,
    output logic [IDX_W-1:0] idx,
    output logic [CW_W-1:0]  wr_data,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    copy_phase_t     ph;
    logic [CW_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_READ;
            idx    <= '0;
            hold_q <= '0;
        end else if (start) begin
            ph  <= PH_READ;
            idx <= '0;
        end else if (run) begin
            unique case (ph)
                PH_READ: ph <= PH_WAIT;
                PH_WAIT: if (rd_valid) begin
                    hold_q <= rd_data;
                    ph     <= PH_WRITE;
                end
                PH_WRITE: if (wr_ack) begin
                    ph <= PH_READ;
                    if (idx != LAST) idx <= idx + 1'b1;
                end
                default: ph <= PH_READ;
            endcase
        end
    end

    always_comb begin
        rd_req  = run && (ph == PH_READ);
        wr_req  = run && (ph == PH_WRITE);
        wr_data = hold_q;
        done    = run && (ph == PH_WRITE) && wr_ack && (idx == LAST);
    end
endmodule

// File: rtl/remap_reg.sv
module remap_reg #(
    parameter int RID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RID_W-1:0] load_region,
    input  logic [RID_W-1:0] host_region,
    output logic             map_active,
    output logic [RID_W-1:0] map_region,
    output logic             host_to_spare
);
    // one register write moves the whole mapping at once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_active <= 1'b0;
            map_region <= '0;
        end else if (load) begin
            map_active <= 1'b1;
            map_region <= load_region;
        end
    end

    always_comb host_to_spare = map_active && (host_region == map_region);
endmodule

// File: rtl/spare_migrator.sv
module spare_migrator
    import spare_mig_pkg::*;
#(
    parameter  int CW_W  = 72,
    parameter  int WORDS = 16,
    parameter  int RID_W = 2,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spare_req,
    input  logic [RID_W-1:0] spare_target,
    input  logic             spare_restock,
    input  logic             host_busy,
    input  logic [RID_W-1:0] host_region,
    output logic             host_stall,
    output logic             host_to_spare,
    output logic             rd_req,
    output logic [RID_W-1:0] rd_region,
    output logic [IDX_W-1:0] rd_addr,
    input  logic             rd_valid,
    input  logic [CW_W-1:0]  rd_data,
    output logic             wr_req,
    output logic [IDX_W-1:0] wr_addr,
    output logic [CW_W-1:0]  wr_data,
    input  logic             wr_ack,
    output logic             busy,
    output logic             spare_avail,
    output logic             replace_needed
);
    mig_state_t       state;
    logic             accept;
    logic             copy_done;
    logic             host_block;
    logic             map_active;
    logic [RID_W-1:0] map_region;
    logic [RID_W-1:0] target_q;
    logic [IDX_W-1:0] idx;

    mig_fsm i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req            (spare_req),
        .restock        (spare_restock),
        .host_busy      (host_busy),
        .copy_done      (copy_done),
        .state          (state),
        .accept         (accept),
        .spare_avail    (spare_avail),
        .replace_needed (replace_needed)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      target_q <= '0;
        else if (accept) target_q <= spare_target;
    end

    copy_engine #(.CW_W(CW_W), .WORDS(WORDS)) i_copy (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (state == ST_HALT && !host_busy),
        .run      (state == ST_COPY),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .wr_ack   (wr_ack),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .idx      (idx),
        .wr_data  (wr_data),
        .done     (copy_done)
    );

    remap_reg #(.RID_W(RID_W)) i_map (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (state == ST_SWITCH),
        .load_region   (target_q),
        .host_region   (host_region),
        .map_active    (map_active),
        .map_region    (map_region),
        .host_to_spare (host_to_spare)
    );

    always_comb begin
        host_block = (state == ST_HALT) || (state == ST_COPY) || (state == ST_SWITCH);
        host_stall = host_block && (host_region == target_q);
        rd_region  = target_q;
        rd_addr    = idx;
        wr_addr    = idx;
        busy       = (state != ST_IDLE);
    end

    assert_copy_fenced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || wr_req) |-> host_block);

    assert_wr_codeword_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> ($past(rd_valid) && wr_data == $past(rd_data)));

    assert_map_only_in_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SWITCH) |=> $stable({map_active, map_region}));

    assert_replace_after_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(replace_needed) |-> map_active);

    assert_copy_no_spare_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || wr_req) |-> !spare_avail);
endmodule

// File: tb/test_spare_migrator.sv
`timescale 1ns/1ps
module test_spare_migrator;
    localparam int CW_W  = 72;
    localparam int WORDS = 16;
    localparam int RID_W = 2;
    localparam int IDX_W = $clog2(WORDS);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             spare_req, spare_restock, host_busy;
    logic [RID_W-1:0] spare_target, host_region;
    logic             host_stall, host_to_spare;
    logic             rd_req, rd_valid, wr_req, wr_ack;
    logic [RID_W-1:0] rd_region;
    logic [IDX_W-1:0] rd_addr, wr_addr;
    logic [CW_W-1:0]  rd_data, wr_data;
    logic             busy, spare_avail, replace_needed;

    int total = 0;
    int bad   = 0;
    int writes_seen = 0;
    int rd_seq = 0;
    logic [RID_W-1:0] exp_region = '0;
    logic [CW_W-1:0]  mem [1<<RID_W][WORDS];
    logic [IDX_W+CW_W-1:0] exp_q [$];

    always #2.5 clk = ~clk;

    spare_migrator #(.CW_W(CW_W), .WORDS(WORDS), .RID_W(RID_W)) i_spare_migrator (
        .clk(clk), .rst_n(rst_n), .spare_req(spare_req), .spare_target(spare_target),
        .spare_restock(spare_restock), .host_busy(host_busy), .host_region(host_region),
        .host_stall(host_stall), .host_to_spare(host_to_spare), .rd_req(rd_req),
        .rd_region(rd_region), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .busy(busy), .spare_avail(spare_avail), .replace_needed(replace_needed)
    );

    task automatic check(input bit ok, input string req, input logic [CW_W+IDX_W-1:0] act,
                         input logic [CW_W+IDX_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic fill_mem(input int seed);
        for (int r = 0; r < (1 << RID_W); r++)
            for (int w = 0; w < WORDS; w++)
                mem[r][w] = {8'(seed * 3 + w), 32'(r * 32'h0100_0193 + w * 32'h9E37_79B9 + seed),
                             32'(~(w * seed) ^ r)};
    endtask

    // driver side of the scoreboard: expected spare writes in order
    task automatic expect_region(input logic [RID_W-1:0] r);
        exp_region = r;
        rd_seq = 0;
        for (int w = 0; w < WORDS; w++) exp_q.push_back({IDX_W'(w), mem[r][w]});
    endtask

    // memory responder and scoreboard monitor
    initial begin : responder
        logic pend;
        logic [RID_W-1:0] p_reg;
        logic [IDX_W-1:0] p_addr;
        logic wwait;
        logic [IDX_W+CW_W-1:0] exp_item;
        pend = 1'b0; p_reg = '0; p_addr = '0; wwait = 1'b0;
        rd_valid = 1'b0; rd_data = '0; wr_ack = 1'b0;
        forever begin
            @(negedge clk);
            rd_valid = pend;
            rd_data  = pend ? mem[p_reg][p_addr] : '0;
            pend = rd_req; p_reg = rd_region; p_addr = rd_addr;
            if (rd_req) begin
                check(rd_region == exp_region && rd_addr == IDX_W'(rd_seq), "R3 read order",
                      {rd_region, rd_addr}, {exp_region, IDX_W'(rd_seq)});
                rd_seq++;
            end
            if (wr_req) begin
                if (wwait) begin
                    wr_ack = 1'b1;
                    wwait  = 1'b0;
                    writes_seen++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3 unexpected write", {wr_addr, wr_data}, '0);
                    end else begin
                        exp_item = exp_q.pop_front();
                        check({wr_addr, wr_data} == exp_item, "R3 spare write",
                              {wr_addr, wr_data}, exp_item);
                    end
                end else begin
                    wr_ack = 1'b0;
                    wwait  = 1'b1;
                end
            end else begin
                wr_ack = 1'b0;
                wwait  = 1'b0;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "R5 watchdog (1=running 0=finished)", 1, 0);
        summary();
        $finish;
    end

    task automatic pulse_req(input logic [RID_W-1:0] r);
        spare_target = r; spare_req = 1'b1;
        @(negedge clk);
        spare_req = 1'b0;
    endtask

    task automatic pulse_restock();
        spare_restock = 1'b1;
        @(negedge clk);
        spare_restock = 1'b0;
    endtask

    task automatic probe_spare(input logic [RID_W-1:0] r, input bit exp, input string req);
        host_region = r;
        #0.1;
        check(host_to_spare == exp, req, host_to_spare, exp);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && !replace_needed; i++) @(negedge clk);
        check(replace_needed == 1'b1, "R5 replace_needed", replace_needed, 1);
    endtask

    initial begin : driver
        rst_n = 1'b0; spare_req = 1'b0; spare_restock = 1'b0; host_busy = 1'b0;
        spare_target = '0; host_region = '0;
        fill_mem(1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(busy == 0 && spare_avail == 1 && replace_needed == 0, "R8 flags",
              {busy, spare_avail, replace_needed}, 3'b010);
        check(!rd_req && !wr_req, "R8 no copy", {rd_req, wr_req}, 0);
        probe_spare(2, 0, "R8 no remap");

        // first migration of region 2, host still busy
        expect_region(2);
        host_busy = 1'b1;
        pulse_req(2);
        check(busy == 1, "R1 accepted", busy, 1);
        check(spare_avail == 0, "R6 spare consumed", spare_avail, 0);
        host_region = 2; #0.1;
        check(host_stall == 1, "R2 stall target", host_stall, 1);
        host_region = 1; #0.1;
        check(host_stall == 0, "R2 other region free", host_stall, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(rd_req == 0, "R2 copy waits for drain", rd_req, 0);
        end
        host_region = 2;
        host_busy = 1'b0;
        wait_done();
        check(writes_seen == WORDS && exp_q.size() == 0, "R3 all words", writes_seen, WORDS);
        host_region = 2; #0.1;
        check(host_stall == 0 && busy == 0, "R5 resumed", {host_stall, busy}, 0);
        probe_spare(2, 1, "R4 target remapped");
        probe_spare(0, 0, "R4 others untouched");

        // request with no spare is ignored
        pulse_req(3);
        check(busy == 0, "R1 ignored without spare", busy, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(rd_req == 0 && busy == 0, "R1 no copy", {rd_req, busy}, 0);
        end
        probe_spare(3, 0, "R1 map unchanged");
        probe_spare(2, 1, "R1 map kept");

        // restock in IDLE
        pulse_restock();
        check(spare_avail == 1 && replace_needed == 0, "R6 restock",
              {spare_avail, replace_needed}, 2'b10);
        probe_spare(2, 1, "R6 mapping kept");

        // second migration of region 1 with late request and restock
        fill_mem(7);
        writes_seen = 0;
        expect_region(1);
        pulse_req(1);
        repeat (10) @(negedge clk);
        pulse_req(3);
        pulse_restock();
        wait_done();
        check(writes_seen == WORDS && exp_q.size() == 0, "R3 second copy", writes_seen, WORDS);
        check(spare_avail == 0, "R7 restock ignored in copy", spare_avail, 0);
        probe_spare(1, 1, "R4 new region remapped");
        probe_spare(2, 0, "R4 old region released");
        probe_spare(3, 0, "R1 late request ignored");

        summary();
        $finish;
    end
endmodule